// File: doc/BRIEF.md
# Reset Source Controller

This block merges four reset requests into a single synchronous system reset for a small microcontroller. The requests are an active-low external reset pin, a missing-clock detector, a one-cycle watchdog timeout pulse and a supply-voltage monitor comparator. All logic runs on a free-running reference clock. The monitored system clock, the pin and the comparator output each pass through a two-flop synchronizer. The watchdog pulse is taken to be synchronous to the reference clock already.

Once the last request goes away, the system reset stays asserted for a parameterized number of reference cycles. When the reset ends, the block records exactly one cause in a cause register. Software reads and writes two 8-bit registers over a simple bus: the cause register and a monitor-control register. In the cause register, some bits read back as flags but act as enables when written. The block also produces a clock-enable strobe for the watchdog at one twelfth of the system clock. It drives the external pin low only for resets raised by the supply monitor.

Top module: `reset_source_ctrl`

## Requirements
- R1: Holding `ext_rst_n` low raises `sys_rst` two reference cycles after the first sampled low level. After that reset ends, the cause register (`reg_addr`=0) reads 8'h01 (bit 0).
- R2: `sys_rst` stays high for exactly `STRETCH` reference cycles after the last cycle in which any source was requesting.
- R3: While the detector is enabled, `sys_rst` is raised if no synchronized edge of `sys_clk` is seen for `MCD_TIMEOUT` reference cycles. After that reset ends, the cause register reads 8'h04 (bit 2).
- R4: Writing the cause register with bit 2 = 1 enables the missing-clock detector, and writing bit 2 = 0 disables it. On a read, bit 2 returns the cause flag, not the enable.
- R5: A one-cycle `wdt_timeout` pulse raises `sys_rst` on the next cycle. After that reset ends, the cause register reads 8'h20 (bit 5).
- R6: When a reset ends, exactly one cause bit is set, chosen by priority: supply monitor (bit 1), then pin (bit 0), then missing clock (bit 2), then watchdog (bit 5). The other four bits always read 0. After power-on, the cause register reads 8'h00.
- R7: `pin_drive_low` is high only while `sys_rst` is high and the supply monitor is among the sources of that reset. It is never high for resets caused only by the pin, the missing clock or the watchdog.
- R8: `wdt_en` is forced to 1 during any reset and stays 1 until a `wdt_disable` pulse. `wdt_tick` pulses for one cycle per 12 synchronized rising edges of `sys_clk`. The tick count restarts during reset.
- R9: In the monitor-control register (`reg_addr`=1), bit 7 is the monitor on/off control (read/write). Bit 6 reads the synchronized `vmon_above`. Bits 5..0 read 0.
- R10: A low `vmon_above` raises `sys_rst` only when the monitor is on and the select bit is set. The select bit is set by writing bit 1 of the cause register. After that reset ends, the cause register reads 8'h02.
- R11: Register writes issued while `sys_rst` is high have no effect.
- R12: `por_n` low forces `sys_rst` high and clears all cause flags. It sets the detector enable, the monitor select, the monitor on bit and `wdt_en`. The stretch count also restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_clk | input | 1 | Monitored system clock, sampled as data |
| ext_rst_n | input | 1 | External reset pin level, active low |
| wdt_timeout | input | 1 | Watchdog expiry pulse, reference-clock synchronous |
| wdt_disable | input | 1 | Pulse that clears the watchdog enable |
| vmon_above | input | 1 | Supply comparator: 1 when supply is above threshold |
| reg_addr | input | 1 | Register select: 0 cause register, 1 monitor control |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sys_rst | output | 1 | Synchronous system reset, active high |
| pin_drive_low | output | 1 | Request to pull the external reset pin low |
| wdt_en | output | 1 | Watchdog enable |
| wdt_tick | output | 1 | Watchdog clock-enable strobe, system clock / 12 |

## Verification
The assertions assume that `ext_rst_n` and `vmon_above` change at most once per reference cycle. They also assume that `wdt_timeout` is a reference-synchronous pulse and that `sys_clk` toggles no faster than every second reference cycle, so that two ticks can never be adjacent. The bench honours these assumptions: every input changes just after a rising reference edge, and `sys_clk` toggles every two reference cycles whenever it runs. The bench stops `sys_clk` for much longer than the timeout only when it is exercising the missing-clock detector.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int NSRC     = 4;
    localparam int SRC_PIN  = 0;
    localparam int SRC_VMON = 1;
    localparam int SRC_MCD  = 2;
    localparam int SRC_WDT  = 3;

    localparam int CAUSE_PIN_BIT  = 0;
    localparam int CAUSE_VMON_BIT = 1;
    localparam int CAUSE_MCD_BIT  = 2;
    localparam int CAUSE_WDT_BIT  = 5;
    localparam int MON_ON_BIT     = 7;
    localparam int MON_STAT_BIT   = 6;

    typedef logic [NSRC-1:0] src_vec_t;

    // Priority: supply monitor, pin, missing clock, watchdog
    function automatic src_vec_t pick_cause(src_vec_t pend);
        src_vec_t r;
        r = '0;
        if (pend[SRC_VMON])     r[SRC_VMON] = 1'b1;
        else if (pend[SRC_PIN]) r[SRC_PIN]  = 1'b1;
        else if (pend[SRC_MCD]) r[SRC_MCD]  = 1'b1;
        else if (pend[SRC_WDT]) r[SRC_WDT]  = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: RST_VAL, s2: RST_VAL};
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/rsc_clk_mon.sv
module rsc_clk_mon #(
    parameter int MCD_TIMEOUT = 20,
    parameter int TICK_DIV    = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic mcd_en,
    input  logic hold,
    output logic miss,
    output logic tick
);
    localparam int TW = $clog2(MCD_TIMEOUT + 1);
    localparam int DW = $clog2(TICK_DIV);
    localparam logic [TW-1:0] T_MAX = TW'(MCD_TIMEOUT);
    localparam logic [DW-1:0] D_MAX = DW'(TICK_DIV - 1);

    typedef struct packed {
        logic          prev;
        logic [TW-1:0] cnt;
        logic [DW-1:0] div;
        logic          tick;
    } mon_t;

    mon_t st_d, st_q;
    logic edge_seen, rise_seen;

    assign edge_seen = sclk_s ^ st_q.prev;
    assign rise_seen = sclk_s & ~st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sclk_s;
        st_d.tick = 1'b0;
        // missing-clock timeout: any edge restarts the window
        if (!mcd_en || edge_seen)  st_d.cnt = '0;
        else if (st_q.cnt != T_MAX) st_d.cnt = st_q.cnt + 1'b1;
        // watchdog strobe prescaler
        if (hold) begin
            st_d.div = '0;
        end else if (rise_seen) begin
            if (st_q.div == D_MAX) begin
                st_d.div  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miss = mcd_en && (st_q.cnt == T_MAX);
    assign tick = st_q.tick;
endmodule

// File: rtl/reset_source_ctrl.sv
module reset_source_ctrl #(
    parameter int STRETCH     = 8,
    parameter int MCD_TIMEOUT = 20,
    parameter int TICK_DIV    = 12
) (
    input  logic       clk_ref,
    input  logic       por_n,
    input  logic       sys_clk,
    input  logic       ext_rst_n,
    input  logic       wdt_timeout,
    input  logic       wdt_disable,
    input  logic       vmon_above,
    input  logic       reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sys_rst,
    output logic       pin_drive_low,
    output logic       wdt_en,
    output logic       wdt_tick
);
    import rsc_pkg::*;

    localparam int CW = $clog2(STRETCH + 1);
    localparam logic [CW-1:0] S_LOAD = CW'(STRETCH);
    localparam logic [CW-1:0] S_ONE  = CW'(1);

    typedef struct packed {
        logic          rst;
        logic [CW-1:0] cnt;
        src_vec_t      pend;
        src_vec_t      cause;
        logic          mcd_en;
        logic          vm_sel;
        logic          vm_on;
        logic          wdt_en;
    } ctl_t;

    ctl_t st_d, st_q;

    // synchronized inputs: {sys_clk, vmon_above, ext_rst_n}
    logic [2:0] raw_in, syn_in;
    logic       pin_n_s, vm_ok_s, sclk_s;
    logic       mcd_miss;
    src_vec_t   req;
    logic       any_req, releasing;

    assign raw_in = {sys_clk, vmon_above, ext_rst_n};

    rsc_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
        .clk   (clk_ref),
        .rst_n (por_n),
        .din   (raw_in),
        .dout  (syn_in)
    );

    assign pin_n_s = syn_in[0];
    assign vm_ok_s = syn_in[1];
    assign sclk_s  = syn_in[2];

    rsc_clk_mon #(.MCD_TIMEOUT(MCD_TIMEOUT), .TICK_DIV(TICK_DIV)) u_mon (
        .clk    (clk_ref),
        .rst_n  (por_n),
        .sclk_s (sclk_s),
        .mcd_en (st_q.mcd_en),
        .hold   (st_q.rst),
        .miss   (mcd_miss),
        .tick   (wdt_tick)
    );

    always_comb begin
        req           = '0;
        req[SRC_PIN]  = ~pin_n_s;
        req[SRC_VMON] = st_q.vm_on & st_q.vm_sel & ~vm_ok_s;
        req[SRC_MCD]  = mcd_miss;
        req[SRC_WDT]  = wdt_timeout;
    end

    assign any_req = |req;

    always_comb begin
        st_d = st_q;
        // stretch counter reloads while any source is active
        st_d.rst = any_req || (st_q.cnt > S_ONE);
        if (any_req)             st_d.cnt = S_LOAD;
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        releasing = st_q.rst && !st_d.rst;
        // cause accumulation and capture at release
        if (releasing) begin
            st_d.cause = pick_cause(st_q.pend);
            st_d.pend  = '0;
        end else begin
            st_d.pend = (st_q.rst ? st_q.pend : '0) | req;
        end
        // watchdog enable
        if (st_q.rst)         st_d.wdt_en = 1'b1;
        else if (wdt_disable) st_d.wdt_en = 1'b0;
        // register writes, blocked while in reset
        if (reg_wr && !st_q.rst) begin
            if (!reg_addr) begin
                st_d.vm_sel = reg_wdata[CAUSE_VMON_BIT];
                st_d.mcd_en = reg_wdata[CAUSE_MCD_BIT];
            end else begin
                st_d.vm_on = reg_wdata[MON_ON_BIT];
            end
        end
    end

    always_ff @(posedge clk_ref or negedge por_n) begin
        if (!por_n) begin
            st_q        <= '0;
            st_q.rst    <= 1'b1;
            st_q.cnt    <= S_LOAD;
            st_q.mcd_en <= 1'b1;
            st_q.vm_sel <= 1'b1;
            st_q.vm_on  <= 1'b1;
            st_q.wdt_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr) begin
            reg_rdata[CAUSE_PIN_BIT]  = st_q.cause[SRC_PIN];
            reg_rdata[CAUSE_VMON_BIT] = st_q.cause[SRC_VMON];
            reg_rdata[CAUSE_MCD_BIT]  = st_q.cause[SRC_MCD];
            reg_rdata[CAUSE_WDT_BIT]  = st_q.cause[SRC_WDT];
        end else begin
            reg_rdata[MON_ON_BIT]   = st_q.vm_on;
            reg_rdata[MON_STAT_BIT] = vm_ok_s;
        end
    end

    assign sys_rst       = st_q.rst;
    assign pin_drive_low = st_q.rst & st_q.pend[SRC_VMON];
    assign wdt_en        = st_q.wdt_en;
endmodule

// File: rtl/reset_source_ctrl_chk.sv
module reset_source_ctrl_chk #(
    parameter int STRETCH = 8
) (
    input logic       clk_ref,
    input logic       por_n,
    input logic       ext_rst_n,
    input logic       wdt_timeout,
    input logic       reg_addr,
    input logic [7:0] reg_rdata,
    input logic       sys_rst,
    input logic       pin_drive_low,
    input logic       wdt_en,
    input logic       wdt_tick
);
    logic [15:0] run_len;
    logic        seen_rise;

    always_ff @(posedge clk_ref or negedge por_n) begin
        if (!por_n) begin
            run_len   <= '0;
            seen_rise <= 1'b0;
        end else begin
            if (sys_rst && !seen_rise) seen_rise <= seen_rise;
            if (sys_rst) run_len <= (run_len == 16'hFFFF) ? run_len : run_len + 1'b1;
            else         run_len <= '0;
            if ($rose(sys_rst)) seen_rise <= 1'b1;
        end
    end

    AST_PIN_FORCES_RESET: assert property (@(posedge clk_ref) disable iff (!por_n)
        (!ext_rst_n && $past(!ext_rst_n)) |-> ##2 sys_rst); // R1

    AST_STRETCH_LENGTH: assert property (@(posedge clk_ref) disable iff (!por_n)
        ($fell(sys_rst) && seen_rise) |-> (run_len >= 16'(STRETCH))); // R2

    AST_WDT_FORCES_RESET: assert property (@(posedge clk_ref) disable iff (!por_n)
        wdt_timeout |=> sys_rst); // R5

    AST_CAUSE_ONEHOT: assert property (@(posedge clk_ref) disable iff (!por_n)
        (reg_addr == 1'b0) |-> $onehot0(reg_rdata)); // R6

    AST_PIN_DRIVE_IN_RESET: assert property (@(posedge clk_ref) disable iff (!por_n)
        pin_drive_low |-> sys_rst); // R7

    AST_WDT_EN_AFTER_RESET: assert property (@(posedge clk_ref) disable iff (!por_n)
        sys_rst |=> wdt_en); // R8

    AST_TICK_SINGLE: assert property (@(posedge clk_ref) disable iff (!por_n)
        wdt_tick |=> !wdt_tick); // R8

    AST_NO_TICK_IN_RESET: assert property (@(posedge clk_ref) disable iff (!por_n)
        $past(sys_rst) |-> !wdt_tick); // R8
endmodule

bind reset_source_ctrl reset_source_ctrl_chk #(.STRETCH(STRETCH)) u_chk (
    .clk_ref       (clk_ref),
    .por_n         (por_n),
    .ext_rst_n     (ext_rst_n),
    .wdt_timeout   (wdt_timeout),
    .reg_addr      (reg_addr),
    .reg_rdata     (reg_rdata),
    .sys_rst       (sys_rst),
    .pin_drive_low (pin_drive_low),
    .wdt_en        (wdt_en),
    .wdt_tick      (wdt_tick)
);

// File: tb/reset_source_ctrl_tb.sv
module reset_source_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int S  = 8;
    localparam int TO = 20;

    logic       clk_ref = 1'b0;
    logic       por_n = 1'b0;
    logic       sys_clk = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       wdt_timeout = 1'b0;
    logic       wdt_disable = 1'b0;
    logic       vmon_above = 1'b1;
    logic       reg_addr = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sys_rst, pin_drive_low, wdt_en, wdt_tick;

    int n_cmp = 0;
    int n_bad = 0;
    bit sck_run = 1'b1;
    int sck_ph = 0;

    reset_source_ctrl #(.STRETCH(S), .MCD_TIMEOUT(TO), .TICK_DIV(12)) u_dut (
        .clk_ref(clk_ref), .por_n(por_n), .sys_clk(sys_clk), .ext_rst_n(ext_rst_n),
        .wdt_timeout(wdt_timeout), .wdt_disable(wdt_disable), .vmon_above(vmon_above),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sys_rst(sys_rst), .pin_drive_low(pin_drive_low), .wdt_en(wdt_en), .wdt_tick(wdt_tick)
    );

    always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

    // system clock source: toggles every two reference cycles while running
    always begin
        @(posedge clk_ref);
        #1;
        if (sck_run) begin
            if (sck_ph == 1) begin sys_clk = ~sys_clk; sck_ph = 0; end
            else sck_ph = sck_ph + 1;
        end
    end

    // ---------------- behavioural reference model ----------------
    int m_p1, m_p2, m_v1, m_v2, m_c1, m_c2, m_cp;
    int m_mcnt, m_div, m_tick, m_wen, m_men, m_vsel, m_von;
    int m_rst, m_hold, pp, pv, pm, pw, cause;

    task automatic model_por();
        m_p1 = 1; m_p2 = 1; m_v1 = 1; m_v2 = 1; m_c1 = 0; m_c2 = 0; m_cp = 0;
        m_mcnt = 0; m_div = 0; m_tick = 0; m_wen = 1; m_men = 1; m_vsel = 1; m_von = 1;
        m_rst = 1; m_hold = S; pp = 0; pv = 0; pm = 0; pw = 0; cause = 0;
    endtask

    initial model_por();

    always @(posedge clk_ref) begin
        if (!por_n) begin
            model_por();
        end else begin
            int rq_p, rq_v, rq_m, rq_w, any, nxt;
            rq_p = (m_p2 == 0);
            rq_v = m_von && m_vsel && (m_v2 == 0);
            rq_m = m_men && (m_mcnt == TO);
            rq_w = wdt_timeout;
            any  = rq_p || rq_v || rq_m || rq_w;
            // watchdog strobe
            if (m_rst) begin m_div = 0; m_tick = 0; end
            else if (m_c2 && !m_cp) begin
                if (m_div == 11) begin m_div = 0; m_tick = 1; end
                else begin m_div = m_div + 1; m_tick = 0; end
            end else m_tick = 0;
            // missing-clock window
            if (!m_men || (m_c2 != m_cp)) m_mcnt = 0;
            else if (m_mcnt < TO) m_mcnt = m_mcnt + 1;
            if (m_rst) m_wen = 1;
            else if (wdt_disable) m_wen = 0;
            if (reg_wr && !m_rst) begin
                if (!reg_addr) begin m_vsel = reg_wdata[1]; m_men = reg_wdata[2]; end
                else m_von = reg_wdata[7];
            end
            nxt = any || (m_hold > 1);
            if (m_rst && !nxt) begin
                cause = pv ? 2 : pp ? 1 : pm ? 3 : pw ? 4 : 0;
                pp = 0; pv = 0; pm = 0; pw = 0;
            end else begin
                if (!m_rst) begin pp = 0; pv = 0; pm = 0; pw = 0; end
                pp = pp | rq_p; pv = pv | rq_v; pm = pm | rq_m; pw = pw | rq_w;
            end
            m_hold = any ? S : (m_hold > 0 ? m_hold - 1 : 0);
            m_rst = nxt;
            m_cp = m_c2; m_c2 = m_c1; m_c1 = sys_clk;
            m_p2 = m_p1; m_p1 = ext_rst_n;
            m_v2 = m_v1; m_v1 = vmon_above;
        end
    end

    function automatic logic [7:0] model_rdata();
        if (reg_addr) return {m_von[0], m_v2[0], 6'b0};
        case (cause)
            1: return 8'h01;
            2: return 8'h02;
            3: return 8'h04;
            4: return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk_ref) begin
        if (por_n) begin
            chk("R2 sys_rst vs model", {7'b0, sys_rst}, 8'(m_rst));
            chk("R6/R9 reg_rdata vs model", reg_rdata, model_rdata());
            chk("R7 pin_drive_low vs model", {7'b0, pin_drive_low}, 8'(m_rst && pv));
            chk("R8 wdt_en vs model", {7'b0, wdt_en}, 8'(m_wen));
            chk("R8 wdt_tick vs model", {7'b0, wdt_tick}, 8'(m_tick));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk_ref);
        #1;
    endtask

    task automatic wr(logic a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        cyc(1);
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic sample(string tag, logic [7:0] act_sel, logic [7:0] exp);
        @(negedge clk_ref);
        chk(tag, act_sel, exp);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int hi;
        // R12: power-on state
        cyc(3);
        @(negedge clk_ref); chk("R12 sys_rst during por", {7'b0, sys_rst}, 8'h01);
        cyc(1); por_n = 1'b1;
        cyc(14);
        @(negedge clk_ref);
        chk("R12 sys_rst released", {7'b0, sys_rst}, 8'h00);
        chk("R6 cause after por", reg_rdata, 8'h00);
        chk("R8 wdt_en after por", {7'b0, wdt_en}, 8'h01);
        cyc(1); reg_addr = 1'b1;
        @(negedge clk_ref); chk("R9 monitor control after por", reg_rdata, 8'hC0);
        cyc(1); reg_addr = 1'b0;

        // R1: external pin
        ext_rst_n = 1'b0; cyc(4);
        @(negedge clk_ref);
        chk("R1 sys_rst while pin low", {7'b0, sys_rst}, 8'h01);
        chk("R7 no pin drive for pin reset", {7'b0, pin_drive_low}, 8'h00);
        cyc(1); ext_rst_n = 1'b1; cyc(15);
        @(negedge clk_ref); chk("R1 cause pin", reg_rdata, 8'h01);

        // R5 + R2: watchdog pulse and stretch length
        cyc(1); wdt_timeout = 1'b1; cyc(1); wdt_timeout = 1'b0;
        hi = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk_ref); if (sys_rst) hi++; end
        chk("R2 stretch cycles", 8'(hi), 8'(S));
        cyc(2);
        @(negedge clk_ref); chk("R5 cause watchdog", reg_rdata, 8'h20);

        // R8: disable and tick stream
        cyc(1); wdt_disable = 1'b1; cyc(1); wdt_disable = 1'b0;
        @(negedge clk_ref); chk("R8 wdt_en cleared", {7'b0, wdt_en}, 8'h00);
        hi = 0;
        for (int i = 0; i < 96; i++) begin @(negedge clk_ref); if (wdt_tick) hi++; end
        chk("R8 ticks in 96 cycles", 8'(hi), 8'd2);

        // R3: missing clock
        cyc(1); sck_run = 1'b0; cyc(30);
        @(negedge clk_ref);
        chk("R3 sys_rst on stopped clock", {7'b0, sys_rst}, 8'h01);
        chk("R7 no pin drive for clock reset", {7'b0, pin_drive_low}, 8'h00);
        chk("R8 wdt_en back on", {7'b0, wdt_en}, 8'h01);
        cyc(1); sck_run = 1'b1; cyc(20);
        @(negedge clk_ref); chk("R3 cause missing clock", reg_rdata, 8'h04);

        // R4: detector disabled by write of 0 to bit 2
        cyc(1); wr(1'b0, 8'h00);
        sck_run = 1'b0;
        hi = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk_ref); if (sys_rst) hi++; end
        chk("R4 no reset when disabled", 8'(hi), 8'h00);
        chk("R4 bit 2 reads flag", reg_rdata, 8'h04);
        cyc(1); sck_run = 1'b1; cyc(4);
        wr(1'b0, 8'h04);

        // R10: supply monitor gating
        vmon_above = 1'b0; cyc(10);
        @(negedge clk_ref); chk("R10 no reset without select", {7'b0, sys_rst}, 8'h00);
        cyc(1); reg_addr = 1'b1;
        @(negedge clk_ref); chk("R9 status low", reg_rdata, 8'h80);
        cyc(1); reg_addr = 1'b0; vmon_above = 1'b1; cyc(3);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h06);
        vmon_above = 1'b0; cyc(10);
        @(negedge clk_ref); chk("R10 no reset when monitor off", {7'b0, sys_rst}, 8'h00);
        cyc(1); reg_addr = 1'b1;
        @(negedge clk_ref); chk("R9 off and status low", reg_rdata, 8'h00);
        cyc(1);
        wr(1'b1, 8'h80);
        cyc(3);
        @(negedge clk_ref);
        chk("R10 reset when on and selected", {7'b0, sys_rst}, 8'h01);
        chk("R7 pin drive for supply reset", {7'b0, pin_drive_low}, 8'h01);
        cyc(1); vmon_above = 1'b1; cyc(20);
        @(negedge clk_ref); chk("R10 cause supply", reg_rdata, 8'h02);

        // R6: priority
        cyc(1); ext_rst_n = 1'b0; wdt_timeout = 1'b1; cyc(1); wdt_timeout = 1'b0;
        cyc(3); ext_rst_n = 1'b1; cyc(15);
        @(negedge clk_ref); chk("R6 pin beats watchdog", reg_rdata, 8'h01);
        cyc(1); ext_rst_n = 1'b0; vmon_above = 1'b0; cyc(4);
        ext_rst_n = 1'b1; vmon_above = 1'b1; cyc(15);
        @(negedge clk_ref); chk("R6 supply beats pin", reg_rdata, 8'h02);

        // R11: writes during reset ignored
        cyc(1); ext_rst_n = 1'b0; cyc(5);
        wr(1'b0, 8'h00);
        ext_rst_n = 1'b1; cyc(15);
        @(negedge clk_ref); chk("R11 cause pin", reg_rdata, 8'h01);
        cyc(1); sck_run = 1'b0; cyc(30);
        @(negedge clk_ref); chk("R11 detector still enabled", {7'b0, sys_rst}, 8'h01);
        cyc(1); sck_run = 1'b1; cyc(20);
        @(negedge clk_ref); chk("R3 cause after late clock reset", reg_rdata, 8'h04);

        cyc(2);
        finish_run();
    end
endmodule